// File: doc/BRIEF.md
# Holdover DAC and Loss-of-Signal Controller

This block drives the 10-bit code of a tuning DAC that steers the oscillator of a clock-cleaning PLL, and watches one reference clock for loss of activity. In normal operation a comparator bit reports whether the loop tuning voltage sits above or below the DAC output. At a fixed, divided update rate the tracked code walks one step towards it, but only while the loop reports lock. The code starts at midscale after reset and stops at both ends of the range.

In holdover the tracked code is frozen. Holdover is entered either by a software force bit or automatically on loss of signal. While holdover is active the output shows either a programmed manual code or the frozen tracked code, depending on the manual-mode bit. The loss-of-signal timer reloads on every rising edge of the synchronized reference. When it runs out within one of four selectable windows, it raises a loss flag and a one-cycle clock-switch request.

The configuration fields are held in a small register inside the block. That register is loaded from the `cfg_*` inputs by a load strobe.

Top module: `holdover_dac_ctrl`

## Requirements
- R1: During and right after reset, `dac_code` is 512, and `los_flag`, `switch_req` and `holdover_active` are 0.
- R2: The configuration register resets with tracking enabled, loss detection disabled, holdover force off, manual mode on and manual code 0x200. A `cfg_load` pulse makes all fields take effect from the next clock cycle.
- R3: While tracking is enabled, `pll_locked` is 1 and holdover is inactive, the tracked code moves by exactly one step every TRACK_DIV cycles. It moves up when `tune_above` is 1 and down when it is 0.
- R4: The tracked code does not change while `pll_locked` is 0 or tracking is disabled.
- R5: The tracked code saturates at 1023 going up and at 0 going down.
- R6: With force on and manual mode on, `dac_code` equals the manual code, `holdover_active` is 1, and the tracked code does not move.
- R7: With force on and manual mode off, `dac_code` equals the frozen tracked code. With force off and no loss of signal, `dac_code` equals the tracked code.
- R8: Window codes 0, 1, 2 and 3 select 2700, 480, 115 and 45 ns. Each gives a reload of floor(SYS_CLK_HZ·ns/1e9) cycles. `los_flag` rises exactly reload+3 clock edges after the reference rises, counting the edge that samples it.
- R9: `switch_req` is a single-cycle pulse in the first cycle that `los_flag` is 1.
- R10: A loss of signal sets `holdover_active` and freezes the tracked code. The loss flag clears three edges after the next rising reference edge.
- R11: With loss detection disabled, `los_flag` and `switch_req` stay 0 whatever the reference does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Loads all cfg_* fields into the configuration register |
| cfg_los_window | input | 2 | Loss timeout select (0 longest, 3 shortest) |
| cfg_los_en | input | 1 | Loss-of-signal detection enable |
| cfg_track_en | input | 1 | Tracking enable |
| cfg_force | input | 1 | Force holdover |
| cfg_man_en | input | 1 | Manual code shown in holdover |
| cfg_man_code | input | 10 | Manual DAC code |
| pll_locked | input | 1 | PLL lock indicator |
| tune_above | input | 1 | Comparator: tuning voltage above DAC output |
| ref_clk | input | 1 | Reference clock being monitored (asynchronous) |
| dac_code | output | 10 | DAC code to the converter |
| los_flag | output | 1 | Loss of signal detected |
| switch_req | output | 1 | One-cycle clock-switch request |
| holdover_active | output | 1 | Holdover in effect (forced or by loss) |

## Verification
The bench builds the block with SYS_CLK_HZ = 100 MHz and TRACK_DIV = 4. This makes the four reload values 270, 48, 11 and 4 cycles, so every window is swept to its exact edge in a few hundred cycles. A short divider lets a full walk of the code from midscale to 1023 and down to 0 finish in about six thousand cycles. Both saturation points are therefore reached, and step counts can be predicted from the number of locked cycles.

// File: rtl/holdover_dac_ctrl.sv
module holdover_dac_ctrl #(
  parameter int SYS_CLK_HZ = 500_000_000,
  parameter int TRACK_DIV  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic [1:0] cfg_los_window,
  input  logic       cfg_los_en,
  input  logic       cfg_track_en,
  input  logic       cfg_force,
  input  logic       cfg_man_en,
  input  logic [9:0] cfg_man_code,
  input  logic       pll_locked,
  input  logic       tune_above,
  input  logic       ref_clk,
  output logic [9:0] dac_code,
  output logic       los_flag,
  output logic       switch_req,
  output logic       holdover_active
);
  localparam logic [63:0] RL0 = (64'(SYS_CLK_HZ) * 64'd2700) / 64'd1000000000;
  localparam logic [63:0] RL1 = (64'(SYS_CLK_HZ) * 64'd480)  / 64'd1000000000;
  localparam logic [63:0] RL2 = (64'(SYS_CLK_HZ) * 64'd115)  / 64'd1000000000;
  localparam logic [63:0] RL3 = (64'(SYS_CLK_HZ) * 64'd45)   / 64'd1000000000;
  localparam int CW = $clog2(RL0 + 64'd2);
  localparam int DW = (TRACK_DIV > 1) ? $clog2(TRACK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TRACK_DIV - 1);

  logic [1:0] win_q;
  logic       los_en_q, track_en_q, force_q, man_en_q;
  logic [9:0] man_code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= 2'd0;
      los_en_q   <= 1'b0;
      track_en_q <= 1'b1;
      force_q    <= 1'b0;
      man_en_q   <= 1'b1;
      man_code_q <= 10'h200;
    end else if (cfg_load) begin
      win_q      <= cfg_los_window;
      los_en_q   <= cfg_los_en;
      track_en_q <= cfg_track_en;
      force_q    <= cfg_force;
      man_en_q   <= cfg_man_en;
      man_code_q <= cfg_man_code;
    end
  end

  logic [2:0] ref_sync;
  wire ref_edge = ref_sync[1] & ~ref_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[1:0], ref_clk};
  end

  logic [CW-1:0] reload, cnt;
  always_comb begin
    case (win_q)
      2'd0:    reload = CW'(RL0);
      2'd1:    reload = CW'(RL1);
      2'd2:    reload = CW'(RL2);
      default: reload = CW'(RL3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= CW'(RL0);
    else if (!los_en_q || ref_edge) cnt <= reload;
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  logic los_q;
  assign los_flag = los_en_q && (cnt == '0);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_q <= 1'b0;
    else        los_q <= los_flag;
  end
  assign switch_req      = los_flag & ~los_q;
  assign holdover_active = force_q | los_flag;

  logic [DW-1:0] div;
  wire tick = (div == DIV_LAST);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div <= '0;
    else if (tick) div <= '0;
    else           div <= div + 1'b1;
  end

  logic [9:0] tracked;
  wire step_ok = tick & track_en_q & pll_locked & ~holdover_active;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tracked <= 10'd512;
    else if (step_ok) begin
      if (tune_above && tracked != 10'd1023) tracked <= tracked + 10'd1;
      else if (!tune_above && tracked != 10'd0) tracked <= tracked - 10'd1;
    end
  end

  assign dac_code = (holdover_active && man_en_q) ? man_code_q : tracked;
endmodule

module holdover_dac_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic       los_en_q,
  input logic       pll_locked,
  input logic       track_en_q,
  input logic [9:0] dac_code,
  input logic       los_flag,
  input logic       switch_req,
  input logic       holdover_active
);
  // R6
  holdover_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(holdover_active) && holdover_active && !$past(cfg_load)) |-> $stable(dac_code));
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(holdover_active) && !holdover_active) |->
      ({1'b0, dac_code} == {1'b0, $past(dac_code)} ||
       {1'b0, dac_code} == {1'b0, $past(dac_code)} + 11'd1 ||
       {1'b0, dac_code} + 11'd1 == {1'b0, $past(dac_code)}));
  // R4
  unlocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(holdover_active) && !holdover_active && (!$past(pll_locked) || !$past(track_en_q)))
      |-> $stable(dac_code));
  // R9
  switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> (los_flag ##1 !switch_req));
  // R11
  los_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !los_en_q |-> (!los_flag && !switch_req));
  // R10
  los_holdover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    los_flag |-> holdover_active);
endmodule

bind holdover_dac_ctrl holdover_dac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .los_en_q(los_en_q),
  .pll_locked(pll_locked), .track_en_q(track_en_q), .dac_code(dac_code),
  .los_flag(los_flag), .switch_req(switch_req), .holdover_active(holdover_active));

// File: tb/tb_holdover_dac_ctrl.sv
module tb_holdover_dac_ctrl;
  localparam int HZ  = 100_000_000;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_los_en = 0, cfg_track_en = 1, cfg_force = 0, cfg_man_en = 1;
  logic [1:0] cfg_los_window = 0;
  logic [9:0] cfg_man_code = 10'h200;
  logic pll_locked = 0, tune_above = 0, ref_clk = 0;
  logic [9:0] dac_code;
  logic los_flag, switch_req, holdover_active;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  holdover_dac_ctrl #(.SYS_CLK_HZ(HZ), .TRACK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_los_window(cfg_los_window),
    .cfg_los_en(cfg_los_en), .cfg_track_en(cfg_track_en), .cfg_force(cfg_force),
    .cfg_man_en(cfg_man_en), .cfg_man_code(cfg_man_code), .pll_locked(pll_locked),
    .tune_above(tune_above), .ref_clk(ref_clk), .dac_code(dac_code),
    .los_flag(los_flag), .switch_req(switch_req), .holdover_active(holdover_active));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] w, input logic le, input logic te,
                           input logic fo, input logic me, input logic [9:0] mc);
    cfg_los_window = w; cfg_los_en = le; cfg_track_en = te;
    cfg_force = fo; cfg_man_en = me; cfg_man_code = mc;
    cfg_load = 1;
    @(posedge clk);
    @(negedge clk);
    cfg_load = 0;
  endtask

  function automatic int reload_of(input int w);
    longint ns;
    ns = (w == 0) ? 2700 : (w == 1) ? 480 : (w == 2) ? 115 : 45;
    return int'((longint'(HZ) * ns) / 64'd1000000000);
  endfunction

  task automatic track(input logic up, input int ticks);
    tune_above = up; pll_locked = 1;
    edges(ticks * DIV);
    pll_locked = 0;
  endtask

  int code;

  initial begin
    edges(3);
    // R1
    check("R1 dac", dac_code, 512);
    check("R1 los", los_flag, 0);
    check("R1 switch", switch_req, 0);
    check("R1 holdover", holdover_active, 0);
    rst_n = 1;
    edges(2);
    check("R1 dac after release", dac_code, 512);

    // R2 defaults: loss off, tracking on
    edges(400);
    check("R2 los default off", los_flag, 0);
    track(1, 10);
    check("R2 R3 track up", dac_code, 522);
    track(0, 5);
    check("R3 track down", dac_code, 517);

    // R4
    tune_above = 1; edges(40);
    check("R4 unlocked hold", dac_code, 517);
    cfg_write(0, 0, 0, 0, 0, 10'd0);
    track(1, 10);
    check("R4 track disabled", dac_code, 517);
    cfg_write(0, 0, 1, 0, 0, 10'd0);

    // R5
    track(1, 520);
    check("R5 top saturation", dac_code, 1023);
    track(1, 10);
    check("R5 stays top", dac_code, 1023);
    track(0, 1030);
    check("R5 bottom saturation", dac_code, 0);
    track(1, 4);
    check("R3 leave bottom", dac_code, 4);

    // R6
    cfg_write(0, 0, 1, 1, 1, 10'd777);
    check("R6 manual code", dac_code, 777);
    check("R6 holdover", holdover_active, 1);
    track(1, 10);
    check("R6 manual held", dac_code, 777);
    // R7
    cfg_write(0, 0, 1, 1, 0, 10'd777);
    check("R7 frozen tracked", dac_code, 4);
    cfg_write(0, 0, 1, 0, 0, 10'd777);
    check("R7 force off", dac_code, 4);
    check("R7 holdover off", holdover_active, 0);

    // R8 R9 R10 window sweep
    for (int w = 0; w < 4; w++) begin
      int rl;
      rl = reload_of(w);
      ref_clk = 0;
      cfg_write(w[1:0], 0, 1, 0, 0, 10'd0);
      edges(3);
      ref_clk = 1;
      cfg_write(w[1:0], 1, 1, 0, 0, 10'd0);
      edges(rl + 1);
      check($sformatf("R8 w%0d before window", w), los_flag, 0);
      check($sformatf("R9 w%0d no early switch", w), switch_req, 0);
      edges(1);
      check($sformatf("R8 w%0d at window", w), los_flag, 1);
      check($sformatf("R9 w%0d switch pulse", w), switch_req, 1);
      edges(1);
      check($sformatf("R9 w%0d switch single", w), switch_req, 0);
      check($sformatf("R10 w%0d holdover", w), holdover_active, 1);
      code = dac_code;
      track(1, 3);
      check($sformatf("R10 w%0d frozen", w), dac_code, code);
      ref_clk = 0;
      edges(2);
      ref_clk = 1;
      edges(2);
      check($sformatf("R10 w%0d still lost", w), los_flag, 1);
      edges(1);
      check($sformatf("R10 w%0d cleared", w), los_flag, 0);
      ref_clk = 0;
      edges(2);
    end

    // R11
    cfg_write(3, 0, 1, 0, 0, 10'd0);
    edges(60);
    check("R11 disabled no los", los_flag, 0);
    ref_clk = 1; edges(3); ref_clk = 0;
    edges(60);
    check("R11 disabled after edge", los_flag, 0);
    check("R11 no switch", switch_req, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule